// File: doc/BRIEF.md
# Fixed-Size Flow-Control Unit Framer

This block cuts a byte stream from the upper layers into units of exactly 256 bytes. Each unit is built from 242 payload bytes, an 8-byte CRC-64 check field and 6 correction bytes in three interleaved groups. Packets of any length can be placed in the payload area, and a packet that does not fit in one unit continues in the next. The framer never stops: when no payload byte is offered for a slot, that slot carries an idle byte of zero. One unit format is used at every rate, so the block has no mode input and no other encoding. Each framed byte leaves as a byte-wide word and also as four 2-bit symbols. The symbols are sent most significant pair first, and each bit pair is mapped to a level with a Gray code.

The receive side takes a byte-wide unit stream, marked by a start flag on byte 0. It passes the payload bytes straight through. It recomputes the check code and, after the last check byte, issues a verdict pulse that tells whether the unit's payload must be discarded. The correction bytes are skipped, because no decoder is built here.

Top module: `flit_link_framer`

## Requirements
- R1: While reset is applied, and until the internal reset release completes, in_ready, tx_valid, tx_first, rx_out_valid and rx_unit_end are low and tx_sym is 0.
- R2: The framer emits one unit byte every 4 clock cycles, with no break. A unit is 256 bytes. tx_first is high with byte 0, so consecutive tx_first pulses are 1024 cycles apart.
- R3: Bytes 0 to 241 of a unit are payload. in_ready is high for one cycle per payload slot. A byte is taken when in_valid and in_ready are both high, and it appears as tx_data, with tx_valid, in the next cycle. Accepted bytes keep their order.
- R4: A payload slot with no byte accepted carries 0x00.
- R5: Payload acceptance continues across units. A stream longer than the remaining payload slots goes on at byte 0 of the next unit.
- R6: Bytes 242 to 249 hold the CRC-64 of the unit's 242 payload bytes. The polynomial is 0x42F0E1EBA9EA3693. Bits are processed most significant first. The register is preset to all ones for each unit and is not inverted at the end. The most significant CRC byte is sent at byte 242.
- R7: For k = 0, 1, 2, interleave k covers the unit bytes i in 0..249 with i mod 3 = k. Byte 250+2k is the XOR of interleave k, and byte 251+2k is its sum mod 256.
- R8: tx_sym carries the byte bits in pairs, most significant pair first. The first pair is on tx_sym in the same cycle that tx_valid is high. The pair maps to a level: 00 gives 0, 01 gives 1, 11 gives 2, 10 gives 3.
- R9: On receive, rx_first marks byte 0. Each received payload byte (positions 0 to 241) appears on rx_out_data, with rx_out_valid, one cycle after it is sampled.
- R10: One cycle after byte 249 is sampled, rx_unit_end pulses. rx_check_error is high with the pulse exactly when any of the 8 received check bytes differs from the CRC (as in R6) of the received payload. That marks the unit's payload invalid.
- R11: Received correction bytes (positions 250 to 255) have no effect on rx_check_error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Framer takes a byte this cycle |
| tx_valid | output | 1 | tx_data holds a new unit byte |
| tx_first | output | 1 | tx_data is byte 0 of a unit |
| tx_data | output | 8 | Framed unit byte |
| tx_sym | output | 2 | Gray-mapped symbol level |
| rx_valid | input | 1 | Received unit byte present |
| rx_first | input | 1 | Received byte is byte 0 of a unit |
| rx_data | input | 8 | Received unit byte |
| rx_out_valid | output | 1 | Received payload byte present |
| rx_out_data | output | 8 | Received payload byte |
| rx_unit_end | output | 1 | Verdict for the received unit |
| rx_check_error | output | 1 | Check code mismatch, payload invalid |

## Verification
The receive side compares the final check byte, at position 249, in the same cycle in which it forms the unit verdict. A mismatch found only on that last byte must still reach rx_check_error along with rx_unit_end. The bench provokes this by flipping one bit of byte 249 on the loopback path, and it judges the verdict of that unit against the verdicts of units whose first check byte or a payload byte was flipped instead. A unit with a flipped correction byte must come out with no error, and the units on either side of each corrupted unit must stay clean.

// File: rtl/flit_pkg.sv
package flit_pkg;
  localparam int unsigned OCTET_W = 8;
  localparam int unsigned CRC_W   = 64;

  typedef logic [OCTET_W-1:0] octet_t;
  typedef logic [CRC_W-1:0]   crc_t;

  // One byte through a CRC shift register, most significant bit first.
  function automatic crc_t crc_step(input crc_t c, input octet_t b, input crc_t poly);
    crc_t r;
    logic fb;
    r = c;
    for (int i = OCTET_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ b[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction
endpackage

// File: rtl/flit_tx_framer.sv
module flit_tx_framer
  import flit_pkg::*;
#(
  parameter int unsigned UNIT_BYTES = 256,
  parameter int unsigned PAY_BYTES  = 242,
  parameter int unsigned CHK_BYTES  = 8,
  parameter int unsigned FEC_WAYS   = 3,
  parameter int unsigned SYM_PER_B  = 4,
  parameter crc_t        CRC_POLY   = 64'h42F0_E1EB_A9EA_3693
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  octet_t in_data,
  output logic   in_ready,
  output logic   byte_load,
  output logic   byte_first,
  output octet_t byte_out
);
  localparam int unsigned SLOT_W    = $clog2(UNIT_BYTES);
  localparam int unsigned PH_W      = $clog2(SYM_PER_B);
  localparam int unsigned WAY_W     = (FEC_WAYS > 1) ? $clog2(FEC_WAYS) : 1;
  localparam int unsigned FEC_BYTES = 2 * FEC_WAYS;
  localparam int unsigned ACC_W     = FEC_BYTES * OCTET_W;
  localparam logic [SLOT_W-1:0] PAY_S  = SLOT_W'(PAY_BYTES);
  localparam logic [SLOT_W-1:0] CHK_S  = SLOT_W'(PAY_BYTES + CHK_BYTES);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(UNIT_BYTES - 1);
  localparam logic [WAY_W-1:0]  WAY_L  = WAY_W'(FEC_WAYS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              run_q;
  crc_t              crc_q, crc_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [WAY_W-1:0]  way_q, way_d;
  octet_t            byte_q, byte_d, nb;
  logic              load_q, load_d, first_q, first_d;
  logic              load_now, in_pay, in_chk;

  assign load_now = run_q && (ph_q == '0);
  assign in_pay   = (slot_q < PAY_S);
  assign in_chk   = !in_pay && (slot_q < CHK_S);
  assign in_ready = load_now && in_pay;

  always_comb begin
    slot_d  = slot_q;
    ph_d    = ph_q;
    crc_d   = crc_q;
    acc_d   = acc_q;
    way_d   = way_q;
    byte_d  = byte_q;
    load_d  = 1'b0;
    first_d = 1'b0;
    nb      = '0;
    if (run_q) ph_d = ph_q + 1'b1;
    if (in_pay)      nb = in_valid ? in_data : '0;
    else if (in_chk) nb = crc_q[CRC_W-1 -: OCTET_W];
    else             nb = acc_q[ACC_W-1 -: OCTET_W];
    if (load_now) begin
      byte_d  = nb;
      load_d  = 1'b1;
      first_d = (slot_q == '0);
      slot_d  = (slot_q == LAST_S) ? '0 : slot_q + 1'b1;
      if (in_pay) crc_d = crc_step(crc_q, nb, CRC_POLY);
      else if (in_chk) crc_d = crc_q << OCTET_W;
      if (in_pay || in_chk) begin
        for (int k = 0; k < FEC_WAYS; k++) begin
          if (way_q == WAY_W'(k)) begin
            acc_d[(FEC_BYTES-1-2*k)*OCTET_W +: OCTET_W] =
              acc_q[(FEC_BYTES-1-2*k)*OCTET_W +: OCTET_W] ^ nb;
            acc_d[(FEC_BYTES-2-2*k)*OCTET_W +: OCTET_W] =
              acc_q[(FEC_BYTES-2-2*k)*OCTET_W +: OCTET_W] + nb;
          end
        end
        way_d = (way_q == WAY_L) ? '0 : way_q + 1'b1;
      end else begin
        acc_d = acc_q << OCTET_W;
      end
      if (slot_q == LAST_S) begin
        crc_d = '1;
        acc_d = '0;
        way_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      ph_q    <= '0;
      run_q   <= 1'b0;
      crc_q   <= '1;
      acc_q   <= '0;
      way_q   <= '0;
      byte_q  <= '0;
      load_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      slot_q  <= slot_d;
      ph_q    <= ph_d;
      crc_q   <= crc_d;
      acc_q   <= acc_d;
      way_q   <= way_d;
      byte_q  <= byte_d;
      load_q  <= load_d;
      first_q <= first_d;
    end
  end

  assign byte_load  = load_q;
  assign byte_first = first_q;
  assign byte_out   = byte_q;

  p_ready_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  p_accept_wire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (byte_load && byte_out == $past(in_data)));
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (byte_load && byte_out == '0));
endmodule

// File: rtl/flit_sym_map.sv
module flit_sym_map
  import flit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  octet_t     byte_i,
  output logic [1:0] sym_o
);
  octet_t     shift_q, shift_d;
  logic [1:0] pair;

  assign pair    = load_i ? byte_i[7:6] : shift_q[7:6];
  assign sym_o   = {pair[1], pair[1] ^ pair[0]};
  assign shift_d = load_i ? (byte_i << 2) : (shift_q << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  p_sym_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sym_o == {$past(byte_i[5]), $past(byte_i[5] ^ byte_i[4])}));
endmodule

// File: rtl/flit_rx_check.sv
module flit_rx_check
  import flit_pkg::*;
#(
  parameter int unsigned UNIT_BYTES = 256,
  parameter int unsigned PAY_BYTES  = 242,
  parameter int unsigned CHK_BYTES  = 8,
  parameter crc_t        CRC_POLY   = 64'h42F0_E1EB_A9EA_3693
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_valid,
  input  logic   rx_first,
  input  octet_t rx_data,
  output logic   out_valid,
  output octet_t out_data,
  output logic   unit_end,
  output logic   check_error
);
  localparam int unsigned SLOT_W = $clog2(UNIT_BYTES);
  localparam logic [SLOT_W-1:0] PAY_S  = SLOT_W'(PAY_BYTES);
  localparam logic [SLOT_W-1:0] CHK_S  = SLOT_W'(PAY_BYTES + CHK_BYTES);
  localparam logic [SLOT_W-1:0] CHK_L  = SLOT_W'(PAY_BYTES + CHK_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(UNIT_BYTES - 1);

  logic [SLOT_W-1:0] pos_q, pos_d, pos;
  crc_t              crc_q, crc_d;
  logic              bad_q, bad_d, mis;
  logic              ov_q, ov_d, end_q, end_d, err_q, err_d;
  octet_t            od_q, od_d;

  assign pos = rx_first ? '0 : pos_q;

  always_comb begin
    pos_d = pos_q;
    crc_d = crc_q;
    bad_d = bad_q;
    ov_d  = 1'b0;
    od_d  = od_q;
    end_d = 1'b0;
    err_d = 1'b0;
    mis   = 1'b0;
    if (rx_valid) begin
      pos_d = (pos == LAST_S) ? '0 : pos + 1'b1;
      if (pos < PAY_S) begin
        ov_d  = 1'b1;
        od_d  = rx_data;
        crc_d = crc_step((pos == '0) ? '1 : crc_q, rx_data, CRC_POLY);
        if (pos == '0) bad_d = 1'b0;
      end else if (pos < CHK_S) begin
        mis   = (rx_data != crc_q[CRC_W-1 -: OCTET_W]);
        crc_d = crc_q << OCTET_W;
        bad_d = bad_q | mis;
        if (pos == CHK_L) begin
          end_d = 1'b1;
          err_d = bad_q | mis;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      crc_q <= '1;
      bad_q <= 1'b0;
      ov_q  <= 1'b0;
      od_q  <= '0;
      end_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      crc_q <= crc_d;
      bad_q <= bad_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
      end_q <= end_d;
      err_q <= err_d;
    end
  end

  assign out_valid   = ov_q;
  assign out_data    = od_q;
  assign unit_end    = end_q;
  assign check_error = err_q;

  p_pay_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first) |=> (out_valid && out_data == $past(rx_data)));
  p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |=> !unit_end);
  p_err_with_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    check_error |-> unit_end);
endmodule

// File: rtl/flit_link_framer.sv
module flit_link_framer
  import flit_pkg::*;
#(
  parameter int unsigned UNIT_BYTES = 256,
  parameter int unsigned PAY_BYTES  = 242,
  parameter int unsigned CHK_BYTES  = 8,
  parameter int unsigned FEC_WAYS   = 3,
  parameter logic [63:0] CRC_POLY   = 64'h42F0_E1EB_A9EA_3693
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx_valid,
  output logic       tx_first,
  output logic [7:0] tx_data,
  output logic [1:0] tx_sym,
  input  logic       rx_valid,
  input  logic       rx_first,
  input  logic [7:0] rx_data,
  output logic       rx_out_valid,
  output logic [7:0] rx_out_data,
  output logic       rx_unit_end,
  output logic       rx_check_error
);
  localparam int unsigned SYM_BITS  = 2;
  localparam int unsigned SYM_PER_B = OCTET_W / SYM_BITS;

  logic [1:0] sync_q;
  logic       rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rs_n = sync_q[1];

  flit_tx_framer #(
    .UNIT_BYTES(UNIT_BYTES), .PAY_BYTES(PAY_BYTES), .CHK_BYTES(CHK_BYTES),
    .FEC_WAYS(FEC_WAYS), .SYM_PER_B(SYM_PER_B), .CRC_POLY(CRC_POLY)
  ) u_tx (
    .clk(clk), .rst_n(rs_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .byte_load(tx_valid), .byte_first(tx_first),
    .byte_out(tx_data)
  );

  flit_sym_map u_map (
    .clk(clk), .rst_n(rs_n), .load_i(tx_valid), .byte_i(tx_data), .sym_o(tx_sym)
  );

  flit_rx_check #(
    .UNIT_BYTES(UNIT_BYTES), .PAY_BYTES(PAY_BYTES), .CHK_BYTES(CHK_BYTES),
    .CRC_POLY(CRC_POLY)
  ) u_rx (
    .clk(clk), .rst_n(rs_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_data(rx_data), .out_valid(rx_out_valid), .out_data(rx_out_data),
    .unit_end(rx_unit_end), .check_error(rx_check_error)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rs_n |-> (!in_ready && !tx_valid && !rx_out_valid && !rx_unit_end));
endmodule

// File: tb/tb_flit_link_framer.sv
module tb_flit_link_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NU   = 6;
  localparam int UB   = 256;
  localparam int PB   = 242;
  localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;
  // {gap slots before, length, first byte, expected start slot}
  localparam logic [31:0] STIM [4] = '{
    {8'd0, 8'd20, 8'h10, 8'd0},
    {8'd3, 8'd35, 8'hA0, 8'd23},
    {8'd5, 8'd1,  8'hFF, 8'd63},
    {8'd2, 8'd40, 8'h3C, 8'd66}
  };

  logic clk, rst_n, in_valid, in_ready, tx_valid, tx_first;
  logic [7:0] in_data, tx_data, rx_data, rx_out_data;
  logic [1:0] tx_sym;
  logic rx_out_valid, rx_unit_end, rx_check_error;

  int total = 0, bad = 0;
  int tu = -1, ts = 0, cyc = 0, last_first = 0;
  int gslot = 0, rxn = 0, rxu = 0, left = 0;
  logic [7:0] sh;
  logic [7:0] exp_pay [NU*PB];
  logic [7:0] txcap [NU*UB];
  logic [7:0] rxcap [NU*PB];
  logic       rxerr [NU];

  function automatic int corr_slot(input int u);
    case (u)
      2: return 5;
      3: return 249;
      4: return 252;
      5: return 242;
      default: return -1;
    endcase
  endfunction

  assign rx_data = tx_data ^ ((tx_valid && tu >= 0 && ts == corr_slot(tu)) ? 8'h20 : 8'h00);

  flit_link_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_data(tx_data), .tx_sym(tx_sym), .rx_valid(tx_valid),
    .rx_first(tx_first), .rx_data(rx_data), .rx_out_valid(rx_out_valid),
    .rx_out_data(rx_out_data), .rx_unit_end(rx_unit_end),
    .rx_check_error(rx_check_error)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] lvl(input logic [1:0] p);
    case (p)
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      2'b11: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [63:0] ref_crc(input int u);
    logic [63:0] c = '1;
    for (int s = 0; s < PB; s++) begin
      c = c ^ {exp_pay[u*PB+s], 56'b0};
      for (int k = 0; k < 8; k++) c = c[63] ? ((c << 1) ^ POLY) : (c << 1);
    end
    return c;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (tx_valid) begin
      if (tx_first) begin
        if (tu >= 0 && tu < NU) chk(cyc - last_first == 4*UB, "R2 unit spacing", 64'(cyc - last_first), 64'(4*UB));
        tu++; ts = 0; last_first = cyc;
      end else ts++;
      if (tu >= 0 && tu < NU) txcap[tu*UB+ts] = tx_data;
      sh = tx_data; left = 4;
    end
    if (left > 0 && tu < NU) begin
      chk(tx_sym == lvl(sh[7:6]), "R8 symbol", 64'(tx_sym), 64'(lvl(sh[7:6])));
      sh = sh << 2; left--;
    end
    if (rx_out_valid && rxn < NU*PB) begin rxcap[rxn] = rx_out_data; rxn++; end
    if (rx_unit_end && rxu < NU) begin rxerr[rxu] = rx_check_error; rxu++; end
  end

  task automatic slot_step(input bit use_it, input logic [7:0] b);
    forever begin
      @(negedge clk);
      in_valid = 1'b0;
      if (in_ready) break;
    end
    if (use_it) begin
      in_valid = 1'b1; in_data = b; exp_pay[gslot] = b;
    end
    gslot++;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    chk(1'b0, "watchdog", 64'(tu), 64'(NU));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] c;
    logic [7:0] x [3];
    logic [7:0] sm [3];
    logic [7:0] e;
    int w;
    int mis;
    for (int i = 0; i < NU*PB; i++) exp_pay[i] = 8'h00;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) begin
      @(negedge clk);
      chk(!in_ready && !tx_valid && !tx_first && !rx_out_valid && !rx_unit_end && tx_sym == 2'd0,
          "R1 reset state", {58'b0, in_ready, tx_valid, rx_out_valid, rx_unit_end, tx_sym}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !tx_valid, "R1 release", {62'b0, in_ready, tx_valid}, 64'd0);
    // table walk: packets with idle gaps in unit 0
    for (int e_i = 0; e_i < 4; e_i++) begin
      for (int g = 0; g < int'(STIM[e_i][31:24]); g++) slot_step(1'b0, 8'h00);
      for (int i = 0; i < int'(STIM[e_i][23:16]); i++)
        slot_step(1'b1, 8'(STIM[e_i][15:8] + 8'(i*7)));
    end
    while (gslot < PB) slot_step(1'b0, 8'h00);
    // long stream filling unit 1 and spilling into unit 2
    for (int i = 0; i < PB + 10; i++) slot_step(1'b1, 8'(i*13 + 5));
    @(negedge clk);
    in_valid = 1'b0;
    while (tu < NU) @(negedge clk);
    repeat (8) @(negedge clk);

    for (int e_i = 0; e_i < 4; e_i++) begin
      chk(txcap[STIM[e_i][7:0]] == STIM[e_i][15:8], "R3 packet start", 64'(txcap[STIM[e_i][7:0]]), 64'(STIM[e_i][15:8]));
      if (STIM[e_i][31:24] != 0)
        chk(txcap[STIM[e_i][7:0]-1] == 8'h00, "R4 idle fill", 64'(txcap[STIM[e_i][7:0]-1]), 64'd0);
    end
    for (int u = 0; u < NU; u++) begin
      mis = 0;
      for (int s = 0; s < PB; s++) if (txcap[u*UB+s] !== exp_pay[u*PB+s]) mis++;
      chk(mis == 0, (u == 2) ? "R5 straddle payload" : "R3 R4 payload", 64'(mis), 64'd0);
      c = ref_crc(u);
      mis = 0;
      for (int k = 0; k < 8; k++) if (txcap[u*UB+PB+k] !== c[63-8*k -: 8]) mis++;
      chk(mis == 0, "R6 check bytes", 64'(mis), 64'd0);
      for (int k = 0; k < 3; k++) begin x[k] = 8'h00; sm[k] = 8'h00; end
      for (int i = 0; i < PB + 8; i++) begin
        e = (i < PB) ? exp_pay[u*PB+i] : c[63-8*(i-PB) -: 8];
        w = i % 3;
        x[w] = x[w] ^ e; sm[w] = sm[w] + e;
      end
      for (int k = 0; k < 3; k++) begin
        chk(txcap[u*UB+250+2*k] == x[k], "R7 xor byte", 64'(txcap[u*UB+250+2*k]), 64'(x[k]));
        chk(txcap[u*UB+251+2*k] == sm[k], "R7 sum byte", 64'(txcap[u*UB+251+2*k]), 64'(sm[k]));
      end
      mis = 0;
      for (int s = 0; s < PB; s++)
        if (rxcap[u*PB+s] !== (exp_pay[u*PB+s] ^ ((u == 2 && s == 5) ? 8'h20 : 8'h00))) mis++;
      chk(mis == 0, "R9 rx payload", 64'(mis), 64'd0);
      if (u == 4)
        chk(rxerr[u] == 1'b0, "R11 correction byte ignored", 64'(rxerr[u]), 64'd0);
      else
        chk(rxerr[u] == (u == 2 || u == 3 || u == 5), "R10 verdict", 64'(rxerr[u]),
            64'(u == 2 || u == 3 || u == 5));
    end
    chk(rxu >= NU, "R10 verdict count", 64'(rxu), 64'(NU));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule